// File: doc/BRIEF.md
# Dual-Issue Warp Dispatch Unit

This block models the issue stage of one multiprocessor in a wide data-parallel engine. A pool of resident warps (48 by default) waits to be sent to four execution groups of unequal width: two 16-lane arithmetic groups, one 16-lane memory group and one 4-lane special-function group. Each warp instruction covers all 32 threads of its warp, so every group stays occupied for a fixed number of cycles after it accepts one. The arithmetic and memory groups are held for two cycles. The special-function group takes a whole warp in one issue slot but is held for eight cycles.

Two schedulers run side by side. Scheduler 0 serves the even-numbered warps and scheduler 1 serves the odd-numbered warps. Each one walks its own warps in round-robin order. An external arm pulse marks a warp ready and records the class of its next operation. When a warp issues it becomes not-ready, and it stays that way until a later arm pulse for the same warp ID re-arms it. Up to two warps can issue in one cycle. If both schedulers want the same free group, scheduler 0 gets it. A scheduler whose chosen warp finds its group occupied stalls on that warp until the group frees.

Top module: `warp_dispatch`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and after it drops, `iss_vld` is 0 and `grp_busy` is 0. No warp is ready and both round-robin pointers sit at the lowest warp. Nothing issues until a warp is armed.
- R2: An arm pulse (`arm_vld` high) marks warp `arm_warp` ready with class `arm_op`. Suppose the arm is sampled at edge N and the warp's group is free. Then the warp issues at edge N+1 and shows on the issue outputs in the cycle after that edge.
- R3: `iss_vld[0]` only ever reports even warp IDs on `iss_warp0`, and `iss_vld[1]` only ever reports odd warp IDs on `iss_warp1`.
- R4: A scheduler's candidate is the first ready warp of its parity, searched in ascending warp order from its pointer and wrapping around. After an issue, the pointer moves to the next warp of that parity after the issued one.
- R5: Class codes 00 and 11 are arithmetic. An arithmetic warp goes to group 0 if that group can accept, otherwise to group 1. Group codes are 0 and 1 for arithmetic, 2 for memory and 3 for special. An arithmetic group stays busy for two cycles per issue and can accept a new warp every second cycle.
- R6: Class code 01 is memory. A memory warp goes to group 2, which stays busy for two cycles per issue.
- R7: Class code 10 is special. A special warp goes to group 3, which stays busy for eight cycles. Two special issues are never closer than eight cycles apart, and a warp waiting on the group issues exactly eight cycles after the previous one.
- R8: When both schedulers need the same group and it can take only one warp, scheduler 0 issues and scheduler 1 retries on later cycles. Two issues in one cycle never name the same group.
- R9: A warp that has issued does not issue again until it is re-armed. An arm pulse for a warp in the same cycle that the warp issues leaves it ready, so it issues again.
- R10: A candidate whose group is occupied stalls its scheduler. No later warp of the same parity issues ahead of it, and it issues as soon as its group can accept.
- R11: An arm pulse whose `arm_warp` is 48 or above has no effect.
- R12: `grp_busy[g]` is high exactly in the cycles during which group g is occupied by an issued warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_vld | input | 1 | Arm pulse: marks a warp ready |
| arm_warp | input | 6 | Warp ID carried by the arm pulse |
| arm_op | input | 2 | Class of the armed warp's next operation |
| iss_vld | output | 2 | Issue strobe per scheduler (bit 0 even, bit 1 odd) |
| iss_warp0 | output | 6 | Warp issued by scheduler 0 |
| iss_warp1 | output | 6 | Warp issued by scheduler 1 |
| iss_grp0 | output | 2 | Group that receives scheduler 0's warp |
| iss_grp1 | output | 2 | Group that receives scheduler 1's warp |
| grp_busy | output | 4 | Per-group occupancy flags |

## Verification
The hardest situation to reach from the ports is two schedulers contending for the special-function group while both are already stalled behind it, with a later warp of the same parity armed behind the stalled one. The stimulus first parks the special group with one warp. During its eight busy cycles it arms an even and an odd special warp and then an arithmetic warp. From the issue times the bench can then read off three things: scheduler 0 winning, the eight-cycle spacing, and head-of-line order. A seeded random phase follows, which arms warps with invalid IDs, re-arms warps and mixes classes. Every cycle of it is compared against a cycle-level model of the requirements.

// File: rtl/wdisp_pkg.sv
package wdisp_pkg;
  typedef enum logic [1:0] {
    OP_ARITH     = 2'b00,
    OP_MEM       = 2'b01,
    OP_SPECIAL   = 2'b10,
    OP_ARITH_ALT = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    GRP_CORE_A  = 2'd0,
    GRP_CORE_B  = 2'd1,
    GRP_MEM     = 2'd2,
    GRP_SPECIAL = 2'd3
  } grp_e;

  localparam int NUM_GROUPS = 4;
  localparam int NUM_SCHED  = 2;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter  int N  = 24,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic          found,
  output logic [IW-1:0] pick
);
  logic [IW-1:0] ptr_q;

  // Search from the pointer upward with wrap; the lowest offset wins.
  always_comb begin
    int idx;
    idx   = 0;
    found = 1'b0;
    pick  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      idx = int'(ptr_q) + i;
      if (idx >= N) idx = idx - N;
      if (req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (advance) ptr_q <= (pick == IW'(N - 1)) ? '0 : pick + 1'b1;
  end

  // R4
  pick_req_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> req[pick]);
  // R10
  adv_found_chk: assert property (@(posedge clk) disable iff (rst)
    advance |-> found);
endmodule

// File: rtl/occ_timer.sv
module occ_timer #(
  parameter  int OCC = 2,
  localparam int CW  = $clog2(OCC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic avail,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= CW'(OCC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // Accepting on the last busy cycle keeps issues exactly OCC apart.
  assign avail = (cnt_q <= CW'(1));
  assign busy  = (cnt_q != '0);

  // R7
  load_free_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> avail);
  // R12
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
endmodule

// File: rtl/warp_dispatch.sv
module warp_dispatch
  import wdisp_pkg::*;
#(
  parameter  int NUM_WARPS   = 48,
  parameter  int CORE_OCC    = 2,
  parameter  int MEM_OCC     = 2,
  parameter  int SPECIAL_OCC = 8,
  localparam int WW  = $clog2(NUM_WARPS),
  localparam int NPS = NUM_WARPS / NUM_SCHED,
  localparam int PW  = (NPS > 1) ? $clog2(NPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  arm_vld,
  input  logic [WW-1:0]         arm_warp,
  input  logic [1:0]            arm_op,
  output logic [1:0]            iss_vld,
  output logic [WW-1:0]         iss_warp0,
  output logic [WW-1:0]         iss_warp1,
  output logic [1:0]            iss_grp0,
  output logic [1:0]            iss_grp1,
  output logic [NUM_GROUPS-1:0] grp_busy
);
  logic [NUM_WARPS-1:0]  ready_q, ready_d;
  logic [1:0]            op_q [NUM_WARPS];
  logic [NUM_SCHED-1:0]  found, go;
  logic [WW-1:0]         cand_warp [NUM_SCHED];
  op_class_e             cand_op   [NUM_SCHED];
  grp_e                  tgt       [NUM_SCHED];
  logic [NUM_GROUPS-1:0] avail, taken;
  logic                  arm_ok;

  assign arm_ok = arm_vld && (int'(arm_warp) < NUM_WARPS);

  // Operation class storage: written on arm, read at two candidate addresses.
  always_ff @(posedge clk) begin
    if (arm_ok) op_q[arm_warp] <= arm_op;
  end

  // Schedulers: s serves warps with ID parity s.
  for (genvar s = 0; s < NUM_SCHED; s++) begin : g_sch
    logic [NPS-1:0] sreq;
    logic [PW-1:0]  pick;
    for (genvar k = 0; k < NPS; k++) begin : g_req
      assign sreq[k] = ready_q[NUM_SCHED * k + s];
    end
    rr_picker #(.N(NPS)) u_pick (
      .clk     (clk),
      .rst     (rst),
      .req     (sreq),
      .advance (go[s]),
      .found   (found[s]),
      .pick    (pick)
    );
    assign cand_warp[s] = WW'(NUM_SCHED * int'(pick) + s);
    assign cand_op[s]   = op_class_e'(op_q[cand_warp[s]]);

    // R9
    issue_ready_chk: assert property (@(posedge clk) disable iff (rst)
      go[s] |-> ready_q[cand_warp[s]]);
  end

  // Group arbitration: scheduler 0 claims first, scheduler 1 takes what is left.
  always_comb begin
    go    = '0;
    taken = '0;
    for (int s = 0; s < NUM_SCHED; s++) begin
      tgt[s] = GRP_CORE_A;
      if (found[s]) begin
        case (cand_op[s])
          OP_MEM: begin
            if (avail[GRP_MEM] && !taken[GRP_MEM]) begin
              go[s] = 1'b1; tgt[s] = GRP_MEM;
            end
          end
          OP_SPECIAL: begin
            if (avail[GRP_SPECIAL] && !taken[GRP_SPECIAL]) begin
              go[s] = 1'b1; tgt[s] = GRP_SPECIAL;
            end
          end
          default: begin
            if (avail[GRP_CORE_A] && !taken[GRP_CORE_A]) begin
              go[s] = 1'b1; tgt[s] = GRP_CORE_A;
            end else if (avail[GRP_CORE_B] && !taken[GRP_CORE_B]) begin
              go[s] = 1'b1; tgt[s] = GRP_CORE_B;
            end
          end
        endcase
        if (go[s]) taken[tgt[s]] = 1'b1;
      end
    end
  end

  // Occupancy timers, one per group.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int OCC_G = (g == int'(GRP_SPECIAL)) ? SPECIAL_OCC :
                           (g == int'(GRP_MEM))     ? MEM_OCC : CORE_OCC;
    occ_timer #(.OCC(OCC_G)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .load  (taken[g]),
      .avail (avail[g]),
      .busy  (grp_busy[g])
    );
  end

  // Ready flags: issue clears, arm sets (arm wins on the same warp).
  always_comb begin
    ready_d = ready_q;
    for (int s = 0; s < NUM_SCHED; s++) begin
      if (go[s]) ready_d[cand_warp[s]] = 1'b0;
    end
    if (arm_ok) ready_d[arm_warp] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ready_q <= '0;
    else     ready_q <= ready_d;
  end

  // Registered issue outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld   <= '0;
      iss_warp0 <= '0;
      iss_warp1 <= '0;
      iss_grp0  <= '0;
      iss_grp1  <= '0;
    end else begin
      iss_vld   <= go;
      iss_warp0 <= cand_warp[0];
      iss_warp1 <= cand_warp[1];
      iss_grp0  <= tgt[0];
      iss_grp1  <= tgt[1];
    end
  end

  // R3
  even_port_chk: assert property (@(posedge clk) disable iff (rst)
    iss_vld[0] |-> !iss_warp0[0]);
  // R3
  odd_port_chk: assert property (@(posedge clk) disable iff (rst)
    iss_vld[1] |-> iss_warp1[0]);
  // R8
  grp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (&iss_vld) |-> (iss_grp0 != iss_grp1));
  // R12
  issued_busy_chk: assert property (@(posedge clk) disable iff (rst)
    iss_vld[0] |-> grp_busy[iss_grp0]);
endmodule

// File: tb/warp_dispatch_test.sv
`timescale 1ns/1ps
module warp_dispatch_test;
  localparam int NW = 48;
  localparam int NP = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arm_vld = 1'b0;
  logic [5:0] arm_warp = '0;
  logic [1:0] arm_op = '0;
  logic [1:0] iss_vld;
  logic [5:0] iss_warp0, iss_warp1;
  logic [1:0] iss_grp0, iss_grp1;
  logic [3:0] grp_busy;

  warp_dispatch uut (
    .clk(clk), .rst(rst), .arm_vld(arm_vld), .arm_warp(arm_warp), .arm_op(arm_op),
    .iss_vld(iss_vld), .iss_warp0(iss_warp0), .iss_warp1(iss_warp1),
    .iss_grp0(iss_grp0), .iss_grp1(iss_grp1), .grp_busy(grp_busy)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit       m_rdy [NW];
  bit [1:0] m_op  [NW];
  int       m_cnt [4];
  int       m_ptr [2];
  bit       e_go  [2];
  int       e_w   [2];
  int       e_g   [2];
  int       iss_cnt  [64];
  int       last_iss [64];

  task automatic check(input bit c, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Occupancy from R5, R6, R7.
  function automatic int occ_of(input int g);
    return (g == 3) ? 8 : 2;
  endfunction

  task automatic model_clear();
    for (int w = 0; w < NW; w++) begin m_rdy[w] = 0; m_op[w] = 0; end
    for (int g = 0; g < 4; g++) m_cnt[g] = 0;
    m_ptr[0] = 0; m_ptr[1] = 0;
    for (int w = 0; w < 64; w++) begin iss_cnt[w] = 0; last_iss[w] = -1; end
  endtask

  task automatic step(input bit av, input int aw, input int ao);
    bit taken [4];
    bit fnd;
    int pk, w, g, act, exp;
    arm_vld = av; arm_warp = 6'(aw); arm_op = 2'(ao);
    for (int k = 0; k < 4; k++) taken[k] = 0;
    for (int s = 0; s < 2; s++) begin
      e_go[s] = 0; e_w[s] = 0; e_g[s] = 0; fnd = 0; pk = 0;
      for (int i = 0; i < NP; i++) begin
        int idx;
        idx = (m_ptr[s] + i) % NP;
        if (!fnd && m_rdy[2 * idx + s]) begin fnd = 1; pk = idx; end
      end
      if (fnd) begin
        w = 2 * pk + s;
        case (m_op[w]) 2'b01: g = 2; 2'b10: g = 3; default: g = 0; endcase
        if (g == 0 && !(m_cnt[0] <= 1 && !taken[0])) g = 1;
        if (m_cnt[g] <= 1 && !taken[g]) begin
          e_go[s] = 1; e_w[s] = w; e_g[s] = g; taken[g] = 1;
          m_ptr[s] = (pk + 1) % NP;
        end
      end
    end
    for (int k = 0; k < 4; k++) begin
      if (taken[k]) m_cnt[k] = occ_of(k);
      else if (m_cnt[k] > 0) m_cnt[k]--;
    end
    for (int s = 0; s < 2; s++) if (e_go[s]) m_rdy[e_w[s]] = 0;
    if (av && aw < NW) begin m_rdy[aw] = 1; m_op[aw] = 2'(ao); end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    act = int'({iss_vld, e_go[1] ? iss_grp1 : 2'd0, e_go[1] ? iss_warp1 : 6'd0,
                e_go[0] ? iss_grp0 : 2'd0, e_go[0] ? iss_warp0 : 6'd0});
    exp = int'({e_go[1], e_go[0], 2'(e_g[1]), 6'(e_w[1]), 2'(e_g[0]), 6'(e_w[0])});
    check(act == exp, "R4", "issue pattern", act, exp);
    exp = int'({m_cnt[3] != 0, m_cnt[2] != 0, m_cnt[1] != 0, m_cnt[0] != 0});
    check(int'(grp_busy) == exp, "R12", "group busy", int'(grp_busy), exp);
    if (iss_vld[0]) begin iss_cnt[iss_warp0]++; last_iss[iss_warp0] = cyc; end
    if (iss_vld[1]) begin iss_cnt[iss_warp1]++; last_iss[iss_warp1] = cyc; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; arm_vld = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(iss_vld == 2'b00, "R1", "iss_vld in reset", int'(iss_vld), 0);
    rst = 1'b0;
    model_clear();
    check(grp_busy == 4'h0, "R1", "busy after reset", int'(grp_busy), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int tot;
    // R1: nothing issues after reset without arming
    do_reset();
    idle(4);
    check(iss_vld == 2'b00, "R1", "idle issue", int'(iss_vld), 0);

    // R2 / R3 / R5: single arithmetic warp
    step(1, 4, 0);
    step(0, 0, 0);
    check(iss_vld == 2'b01 && iss_warp0 == 6'd4 && iss_grp0 == 2'd0, "R2",
          "warp 4 issue", int'({iss_vld, iss_grp0, iss_warp0}), int'({2'b01, 2'd0, 6'd4}));
    check(grp_busy[0], "R5", "core A busy cycle 1", int'(grp_busy[0]), 1);
    step(0, 0, 0);
    check(grp_busy[0], "R5", "core A busy cycle 2", int'(grp_busy[0]), 1);
    step(0, 0, 0);
    check(!grp_busy[0], "R5", "core A free", int'(grp_busy[0]), 0);
    idle(4);
    check(iss_cnt[4] == 1, "R9", "no reissue without arm", iss_cnt[4], 1);

    // R5: second arithmetic warp falls over to core B
    step(1, 6, 3);
    step(1, 8, 0);
    step(0, 0, 0);
    check(iss_vld[0] && iss_warp0 == 6'd8 && iss_grp0 == 2'd1, "R5",
          "core B fallover", int'({iss_grp0, iss_warp0}), int'({2'd1, 6'd8}));
    idle(3);

    // R11: out-of-range arm IDs ignored
    do_reset();
    step(1, 50, 0);
    step(1, 63, 1);
    idle(4);
    tot = 0;
    for (int w = 0; w < 64; w++) tot += iss_cnt[w];
    check(tot == 0, "R11", "issues after bad arm", tot, 0);

    // R6: memory warp on scheduler 1
    step(1, 1, 1);
    step(0, 0, 0);
    check(iss_vld == 2'b10 && iss_warp1 == 6'd1 && iss_grp1 == 2'd2, "R6",
          "memory issue", int'({iss_vld, iss_grp1, iss_warp1}), int'({2'b10, 2'd2, 6'd1}));
    step(0, 0, 0);
    check(grp_busy[2], "R6", "memory busy 2nd cycle", int'(grp_busy[2]), 1);
    step(0, 0, 0);
    check(!grp_busy[2], "R6", "memory free", int'(grp_busy[2]), 0);

    // R7 / R8 / R10: contention behind a parked special group
    do_reset();
    step(1, 0, 2);
    step(1, 2, 2);
    step(1, 3, 2);
    step(1, 4, 0);
    idle(24);
    check(last_iss[2] - last_iss[0] == 8, "R7", "special spacing", last_iss[2] - last_iss[0], 8);
    check(last_iss[3] - last_iss[2] == 8, "R8", "sched 1 after sched 0", last_iss[3] - last_iss[2], 8);
    check(last_iss[4] == last_iss[2] + 1, "R10", "head-of-line order", last_iss[4], last_iss[2] + 1);
    check(iss_cnt[2] == 1, "R10", "stalled warp issued once", iss_cnt[2], 1);

    // R4: pointer order beats arm order
    do_reset();
    step(1, 0, 2);
    step(1, 12, 2);
    step(1, 4, 2);
    idle(20);
    check(last_iss[12] - last_iss[4] == 8, "R4", "round-robin order", last_iss[12] - last_iss[4], 8);

    // R9: arm in the issue cycle keeps the warp ready
    do_reset();
    step(1, 6, 0);
    step(1, 6, 0);
    idle(5);
    check(iss_cnt[6] == 2, "R9", "re-arm during issue", iss_cnt[6], 2);

    // Random phase against the cycle model (R3, R4, R12)
    do_reset();
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) != 0, int'($urandom % 56), int'($urandom % 4));
    end
    idle(10);
    finish_run();
  end
endmodule